// File: doc/BRIEF.md
# Converter Fault Supervisor and Restart Sequencer

This block supervises a switching regulator from a set of digitized comparator flags. Once per switching-clock tick it samples each flag. It qualifies four fault sources, each against its own consecutive-tick count and its own soft-start masking: feedback under-voltage, feedback over-voltage, a shorted high-side switch and die over-temperature. Any qualified fault sets a sticky fault latch and turns the power stage off.

After a fault the block runs a hysteretic handshake on the enable pin. It switches on a current sink and removes the pull-up, then waits until the pin reads below its lower threshold, and then restores the pull-up. A new soft-start is requested only when the pin reads above its upper threshold again. That request also clears the fault latch and every qualification count. An over-temperature fault blocks any restart until the die cool-down flag has been seen. An open timing resistor blocks any start while the part runs in master mode. Power-good is high only in regulation, after soft-start has completed.

Analog comparators, the soft-start ramp and the oscillator sit outside this block. Each one appears only as a single-bit input.

Top module: `conv_fault_supervisor`

## Requirements
- R1: The under-voltage flag sets the fault latch only when it has been high on UV_TICKS (default 16) strictly consecutive ticks while the converter runs. Any tick with the flag low restarts that count from zero.
- R2: Under-voltage never sets the fault latch during soft-start, which is the period from the start request until a tick on which soft-start-done is high.
- R3: The over-voltage flag sets the fault latch after OV_TICKS (default 2) consecutive ticks, including during soft-start. A single isolated tick has no effect.
- R4: A switch-node-high flag sets the fault latch on the same tick only while the low-side switch is commanded on. Either flag alone has no effect.
- R5: The over-temperature flag sets the fault latch on the tick it is seen. No start request is issued after that until a tick with the cool-down flag high has been registered.
- R6: Once the latch is set, the power stage is off, the enable-pin sink is on and the pull-up is off. This holds until a tick on which the pin reads below its lower threshold. From then on the sink is off and the pull-up is on.
- R7: The start request is high only in standby with the pull-up on, on a tick where the pin reads above its upper threshold. The tick that issues it clears the fault latch and enables the power stage.
- R8: Power-good is low whenever the output is out of regulation, in standby, during the handshake and during soft-start. It is high in the running state when the output is in regulation.
- R9: With the timing-resistor-open flag and master mode both high, no start request is issued. In slave mode the resistor flag is ignored.
- R10: While reset is high, and at the first sample after it drops, the block is in standby. The stage is off, the sink is off, the pull-up is on, and the latch, start request and power-good are all low.
- R11: Flags are sampled only on cycles with tick high. With tick low, neither the qualification counts nor the state advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Switching-clock tick enable; flags are sampled when high |
| uv_flag | input | 1 | Feedback below under-voltage threshold |
| ov_flag | input | 1 | Feedback above over-voltage threshold |
| sw_high | input | 1 | Switch node above short-detect level |
| lowside_on | input | 1 | Low-side switch commanded fully on |
| hot_flag | input | 1 | Die above over-temperature trip |
| cool_flag | input | 1 | Die below restart temperature |
| en_above_hi | input | 1 | Enable pin above upper threshold |
| en_below_lo | input | 1 | Enable pin below lower threshold |
| ss_done | input | 1 | Soft-start ramp complete |
| in_reg | input | 1 | Output within regulation window |
| rt_open | input | 1 | Timing resistor detected open |
| master_mode | input | 1 | Oscillator runs as master |
| fault_latched | output | 1 | Sticky fault latch |
| stage_en | output | 1 | Power-stage enable |
| en_sink_on | output | 1 | Enable-pin current sink control |
| en_pullup_on | output | 1 | Enable-pin pull-up control |
| ss_request | output | 1 | New soft-start request (one tick) |
| pgood | output | 1 | Power-good flag |

## Verification
The hardest condition to reach from the ports is the exact edge of under-voltage qualification. That edge is a run one tick shorter than the threshold, and it must be told apart from a run of exactly the threshold length, all inside the running state and not during soft-start. The bench first brings the block through a start and into the running state. It then sweeps run lengths from one to UV_TICKS-1, separating every run with one low tick, and then applies a run of exactly UV_TICKS. At each step it compares the latch against an expected value computed from the length. Restarting after an over-temperature fault needs a similar path: fault, pin discharge, a blocked request with the pin high, and only then the cool-down flag.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [1:0] {
        SEQ_STANDBY   = 2'd0,
        SEQ_SOFTSTART = 2'd1,
        SEQ_RUN       = 2'd2,
        SEQ_DISCHARGE = 2'd3
    } seq_state_e;

    // fault source slots
    localparam int NSRC      = 4;
    localparam int SRC_SHORT = 0;
    localparam int SRC_UV    = 1;
    localparam int SRC_OV    = 2;
    localparam int SRC_HOT   = 3;

    typedef struct packed {
        logic stage_en;
        logic sink_on;
        logic pullup_on;
    } pin_ctl_t;

    // pin and stage drive for each sequencer state
    function automatic pin_ctl_t ctl_for(seq_state_e s);
        pin_ctl_t c;
        c = '{stage_en: 1'b0, sink_on: 1'b0, pullup_on: 1'b1};
        case (s)
            SEQ_SOFTSTART, SEQ_RUN: c.stage_en = 1'b1;
            SEQ_DISCHARGE: begin
                c.sink_on   = 1'b1;
                c.pullup_on = 1'b0;
            end
            default: ;
        endcase
        return c;
    endfunction

    // qualification length per source
    function automatic int src_len(int idx, int uv_len, int ov_len);
        if (idx == SRC_UV) return uv_len;
        if (idx == SRC_OV) return ov_len;
        return 1;
    endfunction

    // sources silenced while soft-start runs
    function automatic bit src_masked_in_ss(int idx);
        return idx == SRC_UV;
    endfunction

    function automatic int cnt_width(int len);
        return (len <= 2) ? 1 : $clog2(len);
    endfunction

endpackage

// File: rtl/fsup_qual.sv
module fsup_qual
    import fsup_pkg::*;
#(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic enable,
    input  logic flag,
    output logic hit
);
    localparam int CW = cnt_width(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            if (!enable || !flag)
                cnt <= '0;
            else if (cnt != LAST)
                cnt <= cnt + 1'b1;
        end
    end

    // flag high this tick, and LEN-1 ticks before it
    assign hit = enable && flag && (cnt == LAST);

    assert_count_restarts_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && !flag) |=> (cnt == '0));

    assert_count_bounded_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    assert_count_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/fsup_seq.sv
module fsup_seq
    import fsup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       any_hit,
    input  logic       hot_flag,
    input  logic       cool_flag,
    input  logic       en_above_hi,
    input  logic       en_below_lo,
    input  logic       ss_done,
    input  logic       in_reg,
    input  logic       start_block,
    output seq_state_e state,
    output logic       fault_latched,
    output logic       stage_en,
    output logic       en_sink_on,
    output logic       en_pullup_on,
    output logic       ss_request,
    output logic       pgood
);
    seq_state_e state_nx;
    logic       hot_lock;
    logic       start_ok;
    logic       active;
    pin_ctl_t   ctl;

    assign active   = (state == SEQ_SOFTSTART) || (state == SEQ_RUN);
    assign start_ok = en_above_hi && !start_block && !hot_lock && !hot_flag;
    assign ss_request = tick && (state == SEQ_STANDBY) && start_ok;

    always_comb begin
        state_nx = state;
        case (state)
            SEQ_STANDBY:   if (ss_request) state_nx = SEQ_SOFTSTART;
            SEQ_SOFTSTART: begin
                if (any_hit)      state_nx = SEQ_DISCHARGE;
                else if (ss_done) state_nx = SEQ_RUN;
            end
            SEQ_RUN:       if (any_hit) state_nx = SEQ_DISCHARGE;
            SEQ_DISCHARGE: if (en_below_lo) state_nx = SEQ_STANDBY;
            default:       state_nx = SEQ_STANDBY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= SEQ_STANDBY;
            fault_latched <= 1'b0;
            hot_lock      <= 1'b0;
        end else if (tick) begin
            state <= state_nx;
            if (ss_request)
                fault_latched <= 1'b0;
            else if (active && any_hit)
                fault_latched <= 1'b1;
            if (hot_flag)
                hot_lock <= 1'b1;
            else if (cool_flag)
                hot_lock <= 1'b0;
        end
    end

    assign ctl          = ctl_for(state);
    assign stage_en     = ctl.stage_en;
    assign en_sink_on   = ctl.sink_on;
    assign en_pullup_on = ctl.pullup_on;
    assign pgood        = (state == SEQ_RUN) && in_reg && !fault_latched;

    assert_stage_off_on_fault_R6: assert property (@(posedge clk) disable iff (rst)
        fault_latched && !ss_request |-> !stage_en);

    assert_sink_pullup_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(en_sink_on && en_pullup_on));

    assert_request_needs_pin_R7: assert property (@(posedge clk) disable iff (rst)
        ss_request |-> en_pullup_on && en_above_hi);

    assert_request_clears_latch_R7: assert property (@(posedge clk) disable iff (rst)
        ss_request |=> !fault_latched && stage_en);

    assert_no_start_when_hot_R5: assert property (@(posedge clk) disable iff (rst)
        ss_request |-> !hot_lock);

    assert_pgood_in_run_R8: assert property (@(posedge clk) disable iff (rst)
        pgood |-> in_reg && stage_en && !fault_latched);

    assert_no_start_rt_open_R9: assert property (@(posedge clk) disable iff (rst)
        ss_request |-> !start_block);

    assert_latch_needs_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_latched) |-> $past(any_hit) && $past(tick));

endmodule

// File: rtl/conv_fault_supervisor.sv
module conv_fault_supervisor
    import fsup_pkg::*;
#(
    parameter int UV_TICKS = 16,
    parameter int OV_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic uv_flag,
    input  logic ov_flag,
    input  logic sw_high,
    input  logic lowside_on,
    input  logic hot_flag,
    input  logic cool_flag,
    input  logic en_above_hi,
    input  logic en_below_lo,
    input  logic ss_done,
    input  logic in_reg,
    input  logic rt_open,
    input  logic master_mode,
    output logic fault_latched,
    output logic stage_en,
    output logic en_sink_on,
    output logic en_pullup_on,
    output logic ss_request,
    output logic pgood
);
    seq_state_e        state;
    logic [NSRC-1:0]   src_flag;
    logic [NSRC-1:0]   src_hit;
    logic              active;
    logic              in_ss;

    assign active = (state == SEQ_SOFTSTART) || (state == SEQ_RUN);
    assign in_ss  = (state == SEQ_SOFTSTART);

    always_comb begin
        src_flag            = '0;
        src_flag[SRC_SHORT] = sw_high && lowside_on;
        src_flag[SRC_UV]    = uv_flag;
        src_flag[SRC_OV]    = ov_flag;
        src_flag[SRC_HOT]   = hot_flag;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int  LEN  = src_len(i, UV_TICKS, OV_TICKS);
        localparam bit  MASK = src_masked_in_ss(i);
        logic en_i;
        assign en_i = active && !(MASK && in_ss);
        fsup_qual #(.LEN(LEN)) u_qual (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .enable (en_i),
            .flag   (src_flag[i]),
            .hit    (src_hit[i])
        );
    end

    fsup_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .any_hit       (|src_hit),
        .hot_flag      (hot_flag),
        .cool_flag     (cool_flag),
        .en_above_hi   (en_above_hi),
        .en_below_lo   (en_below_lo),
        .ss_done       (ss_done),
        .in_reg        (in_reg),
        .start_block   (rt_open && master_mode),
        .state         (state),
        .fault_latched (fault_latched),
        .stage_en      (stage_en),
        .en_sink_on    (en_sink_on),
        .en_pullup_on  (en_pullup_on),
        .ss_request    (ss_request),
        .pgood         (pgood)
    );

    assert_short_same_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && stage_en && sw_high && lowside_on && !ss_request) |=> fault_latched);

    assert_ss_fault_cause_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(fault_latched) && $past(state) == SEQ_SOFTSTART)
            |-> $past(ov_flag || hot_flag || (sw_high && lowside_on)));

    assert_hot_immediate_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && stage_en && hot_flag && !ss_request) |=> fault_latched);

    assert_state_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(fault_latched) && $stable(stage_en));

endmodule

// File: tb/conv_fault_supervisor_test.sv
`timescale 1ns/1ps
module conv_fault_supervisor_test;
    localparam int UVN = 16;
    localparam int OVN = 2;

    logic clk = 1'b0;
    logic rst, tick, uv_flag, ov_flag, sw_high, lowside_on, hot_flag, cool_flag;
    logic en_above_hi, en_below_lo, ss_done, in_reg, rt_open, master_mode;
    logic fault_latched, stage_en, en_sink_on, en_pullup_on, ss_request, pgood;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    conv_fault_supervisor #(.UV_TICKS(UVN), .OV_TICKS(OVN)) uut (.*);

    task automatic chk(string req, string what, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic start_up();
        en_above_hi = 1'b1;
        #1;
        chk("R7", "request with pin high", ss_request, 1'b1);
        cyc(1);
        chk("R7", "stage on after request", stage_en, 1'b1);
        chk("R7", "latch cleared by request", fault_latched, 1'b0);
        en_above_hi = 1'b0;
    endtask

    task automatic go_run();
        ss_done = 1'b1;
        cyc(1);
        ss_done = 1'b0;
    endtask

    task automatic recover();
        en_below_lo = 1'b1;
        cyc(1);
        en_below_lo = 1'b0;
        chk("R6", "pull-up restored", en_pullup_on, 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick = 1'b1;
        uv_flag = 0; ov_flag = 0; sw_high = 0; lowside_on = 0; hot_flag = 0; cool_flag = 0;
        en_above_hi = 0; en_below_lo = 0; ss_done = 0; in_reg = 0; rt_open = 0; master_mode = 0;
        cyc(3);
        rst = 1'b0;
        #1;
        // R10 reset state
        chk("R10", "stage", stage_en, 1'b0);
        chk("R10", "sink", en_sink_on, 1'b0);
        chk("R10", "pull-up", en_pullup_on, 1'b1);
        chk("R10", "latch", fault_latched, 1'b0);
        chk("R10", "pgood", pgood, 1'b0);
        chk("R10", "request", ss_request, 1'b0);

        // R9 open timing resistor in master mode
        rt_open = 1; master_mode = 1; en_above_hi = 1;
        #1;
        chk("R9", "request blocked", ss_request, 1'b0);
        cyc(3);
        chk("R9", "stage stays off", stage_en, 1'b0);
        master_mode = 0;
        #1;
        chk("R9", "slave ignores rt flag", ss_request, 1'b1);
        cyc(1);
        chk("R9", "started in slave", stage_en, 1'b1);
        en_above_hi = 0; rt_open = 0;

        // R2 / R8 soft-start behaviour
        in_reg = 1; uv_flag = 1;
        cyc(UVN + 4);
        chk("R2", "uv masked in soft-start", fault_latched, 1'b0);
        chk("R8", "pgood low in soft-start", pgood, 1'b0);
        uv_flag = 0;
        go_run();
        chk("R8", "pgood in run", pgood, 1'b1);
        in_reg = 0;
        #1;
        chk("R8", "pgood out of regulation", pgood, 1'b0);
        in_reg = 1;

        // R1 run-length sweep
        for (int k = 1; k < UVN; k++) begin
            uv_flag = 1;
            cyc(k);
            chk("R1", "short uv run", fault_latched, logic'(k >= UVN));
            uv_flag = 0;
            cyc(1);
        end
        uv_flag = 1;
        cyc(UVN - 1);
        chk("R1", "one tick short", fault_latched, 1'b0);
        cyc(1);
        chk("R1", "full uv run", fault_latched, 1'b1);
        uv_flag = 0;

        // R6 discharge handshake
        chk("R6", "stage off", stage_en, 1'b0);
        chk("R6", "sink on", en_sink_on, 1'b1);
        chk("R6", "pull-up off", en_pullup_on, 1'b0);
        chk("R8", "pgood low after fault", pgood, 1'b0);
        cyc(5);
        chk("R6", "sink held", en_sink_on, 1'b1);
        recover();
        chk("R6", "sink released", en_sink_on, 1'b0);
        chk("R7", "latch held in standby", fault_latched, 1'b1);
        #1;
        chk("R7", "no request pin low", ss_request, 1'b0);
        start_up();

        // R3 over-voltage during soft-start
        ov_flag = 1;
        cyc(1);
        ov_flag = 0;
        chk("R3", "single ov tick", fault_latched, 1'b0);
        cyc(1);
        ov_flag = 1;
        cyc(OVN);
        chk("R3", "qualified ov in soft-start", fault_latched, 1'b1);
        ov_flag = 0;
        recover();
        start_up();
        go_run();

        // R4 shorted high-side switch
        sw_high = 1; lowside_on = 0;
        cyc(4);
        chk("R4", "switch-node alone", fault_latched, 1'b0);
        sw_high = 0; lowside_on = 1;
        cyc(4);
        chk("R4", "low-side alone", fault_latched, 1'b0);
        sw_high = 1;
        cyc(1);
        chk("R4", "short same tick", fault_latched, 1'b1);
        sw_high = 0; lowside_on = 0;
        recover();
        start_up();
        go_run();

        // R5 over-temperature with hysteresis
        hot_flag = 1;
        cyc(1);
        chk("R5", "hot trip", fault_latched, 1'b1);
        hot_flag = 0;
        recover();
        en_above_hi = 1;
        #1;
        chk("R5", "restart blocked while hot", ss_request, 1'b0);
        cyc(3);
        chk("R5", "stays off while hot", stage_en, 1'b0);
        cool_flag = 1;
        cyc(1);
        cool_flag = 0;
        chk("R5", "request after cool", ss_request, 1'b1);
        cyc(1);
        chk("R5", "restart after cool", stage_en, 1'b1);
        en_above_hi = 0;
        go_run();

        // R11 tick gating
        tick = 0; uv_flag = 1; ov_flag = 1;
        cyc(UVN * 2);
        chk("R11", "no fault without ticks", fault_latched, 1'b0);
        chk("R11", "state held without ticks", stage_en, 1'b1);
        tick = 1;
        cyc(OVN - 1);
        chk("R11", "count starts at first tick", fault_latched, 1'b0);
        cyc(1);
        chk("R11", "ov after ticks resume", fault_latched, 1'b1);
        uv_flag = 0; ov_flag = 0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule